// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 interrupt lines, latches each into a pending bit and forwards the most urgent pending and enabled one to the processor. It reports the number of that interrupt on `req_id` together with a request flag. Software uses a small word-addressed register bus to turn enables on and off, to set or clear pending status and to give every line a two-bit urgency level. Each line can be pulse-sensitive or level-sensitive, and a per-line configuration input selects which. A non-maskable line takes precedence over everything else.

The core accepts a request with `ack`. The accepted interrupt then becomes the active one, and its pending bit is cleared as it is accepted. The core signals the end of a handler with `done`. Active interrupts are held on a stack whose depth equals the number of urgency levels. An interrupt that is strictly more urgent than the active one can preempt it, and `done` brings the controller back to the handler it interrupted. When the outermost handler finishes and another interrupt is waiting, the waiting interrupt becomes active on that same edge and the controller never passes through idle.

The controller is a three-state machine:

- **Idle**: no handler is running.
- **Serve**: at least one configurable handler is on the stack.
- **NMI**: the non-maskable handler is running.

The transitions are:

- **start**: Idle to Serve.
- **nest**: Serve to Serve, with a push.
- **return**: Serve to Serve, with a pop.
- **chain**: Serve to Serve, replacing the only entry on the stack.
- **retire**: Serve to Idle.
- **nmi-enter**: Idle or Serve to NMI.
- **nmi-exit**: NMI back to Idle or Serve, depending on whether the stack is empty.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, pending bit and priority field reads 0, and `req_valid`, `act_valid` and `act_nmi` are 0.
- R2: A write to offset 0x100 sets the enable bits where the data has a 1, and a write to 0x180 clears them. Zero data bits leave a bit unchanged. A read of either offset returns the enable bitmap, with line i at bit i.
- R3: A write to 0x200 sets pending bits, and a write to 0x280 clears them, with the same one-acts/zero-ignored rule. A read of either offset returns the pending bitmap.
- R4: The priority word at offset 0x400+4k holds line 4k+j in bits [8j+7:8j+6]. All other bits of the word read as 0.
- R5: The request names the pending and enabled line with the lowest level value. Among lines with equal levels, the lowest line number wins. Lines that are pending but disabled raise no request.
- R6: A pulse-configured line (`irq_level` bit 0) sets its pending bit on a rising edge. The bit then stays set after the line falls, and a line held high does not set it again once it has been cleared.
- R7: A level-configured line (`irq_level` bit 1) keeps its pending bit set while the line is high, including right after the interrupt has been acknowledged.
- R8: `ack` during a configurable request makes that line active: `act_valid` goes to 1 and `act_id` becomes the requested number on the next cycle, and its pending bit is cleared.
- R9: A request during service appears only for a strictly more urgent level. `done` on a nested handler makes the interrupted line active again.
- R10: `done` on the outermost handler, while another enabled line is pending, makes that line active at once, and `act_valid` stays 1.
- R11: A rising edge on `nmi_in` raises a request with `req_nmi` = 1 whatever the enables are. Its `ack` sets `act_nmi`, and no request appears while it is active. Its `done` returns to the prior state.
- R12: `done` on the outermost handler with nothing pending returns to idle (`act_valid` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_in | input | N_IRQ | Interrupt lines |
| irq_level | input | N_IRQ | Per-line mode: 1 = level, 0 = pulse |
| nmi_in | input | 1 | Non-maskable line, edge-sensitive |
| ack | input | 1 | Core accepts the current request |
| done | input | 1 | Core finishes the active handler |
| req_valid | output | 1 | A request is offered |
| req_nmi | output | 1 | The offered request is the non-maskable one |
| req_id | output | ID_W | Number of the offered configurable line |
| act_valid | output | 1 | A handler is active |
| act_nmi | output | 1 | The active handler is the non-maskable one |
| act_id | output | ID_W | Number of the active configurable line |

## Verification
The bench builds the block with its defaults: 32 lines and two-bit levels, which gives four levels and a four-deep stack. All eight priority words are therefore present, and the selection table can mix every level with ties and disabled lines. The four-level range also lets a three-line scenario exercise nesting, the return to the interrupted handler and chaining at the outermost level. Mixing pulse and level lines shows that acknowledge clears pending in one mode and is overridden in the other.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_NMI   = 2'd2
    } pic_state_t;

    localparam logic [11:0] OFS_EN_SET   = 12'h100;
    localparam logic [11:0] OFS_EN_CLR   = 12'h180;
    localparam logic [11:0] OFS_PEND_SET = 12'h200;
    localparam logic [11:0] OFS_PEND_CLR = 12'h280;
    // priority words occupy 0x400 upwards: bits [11:10] == 2'b01
    localparam logic [1:0]  PRIO_PAGE    = 2'b01;
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 2,
    localparam int ID_W  = $clog2(N_IRQ),
    localparam int N_WRD = (N_IRQ + 3) / 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [N_IRQ-1:0]        irq_in,
    input  logic [N_IRQ-1:0]        irq_level,
    input  logic                    clr_valid,
    input  logic [ID_W-1:0]         clr_id,
    output logic [N_IRQ-1:0]        en_q,
    output logic [N_IRQ-1:0]        pend_q,
    output logic [N_IRQ*PRIO_W-1:0] prio_flat
);
    logic             wr_en_set, wr_en_clr, wr_pd_set, wr_pd_clr, prio_hit, prio_wr;
    logic [7:0]       prio_sel;
    logic [N_IRQ-1:0] irq_q, hw_set, en_d, pend_d;

    assign wr_en_set = bus_sel && bus_wr && (bus_addr == OFS_EN_SET);
    assign wr_en_clr = bus_sel && bus_wr && (bus_addr == OFS_EN_CLR);
    assign wr_pd_set = bus_sel && bus_wr && (bus_addr == OFS_PEND_SET);
    assign wr_pd_clr = bus_sel && bus_wr && (bus_addr == OFS_PEND_CLR);
    assign prio_sel  = bus_addr[9:2];
    assign prio_hit  = (bus_addr[11:10] == PRIO_PAGE) && (bus_addr[1:0] == 2'b00)
                       && (prio_sel < 8'(N_WRD));
    assign prio_wr   = bus_sel && bus_wr && prio_hit;

    // level lines set while high; pulse lines set on a rising edge
    assign hw_set = (irq_in & irq_level) | (irq_in & ~irq_q & ~irq_level);

    always_comb begin
        en_d = en_q;
        if (wr_en_set) en_d = en_d | bus_wdata[N_IRQ-1:0];
        if (wr_en_clr) en_d = en_d & ~bus_wdata[N_IRQ-1:0];
    end

    always_comb begin
        pend_d = pend_q;
        if (wr_pd_clr) pend_d = pend_d & ~bus_wdata[N_IRQ-1:0];
        if (clr_valid) pend_d[clr_id] = 1'b0;
        pend_d = pend_d | hw_set;
        if (wr_pd_set) pend_d = pend_d | bus_wdata[N_IRQ-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            irq_q  <= '0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
            irq_q  <= irq_in;
        end
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_prio
        logic [PRIO_W-1:0] lvl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lvl_q <= '0;
            else if (prio_wr && (prio_sel == 8'(g / 4)))
                lvl_q <= bus_wdata[8*(g%4)+8-PRIO_W +: PRIO_W];
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = lvl_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR)
                bus_rdata[N_IRQ-1:0] = en_q;
            else if (bus_addr == OFS_PEND_SET || bus_addr == OFS_PEND_CLR)
                bus_rdata[N_IRQ-1:0] = pend_q;
            else if (prio_hit) begin
                for (int j = 0; j < 4; j++) begin
                    if (int'(prio_sel) * 4 + j < N_IRQ)
                        bus_rdata[8*j+8-PRIO_W +: PRIO_W] =
                            prio_flat[(int'(prio_sel) * 4 + j) * PRIO_W +: PRIO_W];
                end
            end
        end
    end
endmodule

// File: rtl/pic_select.sv
module pic_select #(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 2,
    localparam int ID_W  = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0]        en_q,
    input  logic [N_IRQ-1:0]        pend_q,
    input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
    output logic                    cand_ok,
    output logic [ID_W-1:0]         cand_id,
    output logic [PRIO_W-1:0]       cand_prio
);
    logic [N_IRQ-1:0] live;
    assign live = en_q & pend_q;

    // descending scan with <= lets the lowest number win a tie
    always_comb begin
        cand_ok   = 1'b0;
        cand_id   = '0;
        cand_prio = '1;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (live[i] && (!cand_ok || prio_flat[i*PRIO_W +: PRIO_W] <= cand_prio)) begin
                cand_ok   = 1'b1;
                cand_id   = ID_W'(i);
                cand_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/pic_sequencer.sv
module pic_sequencer
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 2,
    localparam int ID_W  = $clog2(N_IRQ),
    localparam int LVLS  = 2 ** PRIO_W,
    localparam int SP_W  = $clog2(LVLS),
    localparam int DEP_W = $clog2(LVLS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nmi_in,
    input  logic                    ack,
    input  logic                    done,
    input  logic                    cand_ok,
    input  logic [ID_W-1:0]         cand_id,
    input  logic [PRIO_W-1:0]       cand_prio,
    input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
    output logic                    clr_valid,
    output logic [ID_W-1:0]         clr_id,
    output logic                    req_valid,
    output logic                    req_nmi,
    output logic [ID_W-1:0]         req_id,
    output logic                    act_valid,
    output logic                    act_nmi,
    output logic [ID_W-1:0]         act_id
);
    pic_state_t        state_q, state_d;
    logic [DEP_W-1:0]  dep_q;
    logic [ID_W-1:0]   stk_q [LVLS];
    logic [SP_W-1:0]   top_idx, push_idx;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio;
    logic              nmi_q, nmi_pend, preempt_ok;
    logic              do_push, do_pop, do_chain, nmi_take;

    assign top_idx    = SP_W'(dep_q - 1'b1);
    assign push_idx   = SP_W'(dep_q);
    assign top_id     = stk_q[top_idx];
    assign top_prio   = prio_flat[top_id*PRIO_W +: PRIO_W];
    assign preempt_ok = cand_ok && ((dep_q == '0) || (cand_prio < top_prio));

    // next state and the stack operations of each transition
    always_comb begin
        state_d  = state_q;
        do_push  = 1'b0;
        do_pop   = 1'b0;
        do_chain = 1'b0;
        nmi_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ack && nmi_pend) begin            // nmi-enter
                    nmi_take = 1'b1;
                    state_d  = ST_NMI;
                end else if (ack && preempt_ok) begin // start
                    do_push = 1'b1;
                    state_d = ST_SERVE;
                end
            end
            ST_SERVE: begin
                if (done) begin
                    if (dep_q == DEP_W'(1)) begin
                        if (cand_ok) do_chain = 1'b1; // chain
                        else begin                    // retire
                            do_pop  = 1'b1;
                            state_d = ST_IDLE;
                        end
                    end else
                        do_pop = 1'b1;                // return
                end else if (ack && nmi_pend) begin   // nmi-enter
                    nmi_take = 1'b1;
                    state_d  = ST_NMI;
                end else if (ack && preempt_ok)       // nest
                    do_push = 1'b1;
            end
            ST_NMI: begin
                if (done)                             // nmi-exit
                    state_d = (dep_q == '0) ? ST_IDLE : ST_SERVE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dep_q    <= '0;
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
            for (int k = 0; k < LVLS; k++) stk_q[k] <= '0;
        end else begin
            nmi_q    <= nmi_in;
            nmi_pend <= (nmi_pend && !nmi_take) || (nmi_in && !nmi_q);
            if (do_push) begin
                stk_q[push_idx] <= cand_id;
                dep_q           <= dep_q + 1'b1;
            end else if (do_chain)
                stk_q[top_idx] <= cand_id;
            else if (do_pop)
                dep_q <= dep_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        clr_valid = do_push || do_chain;
        clr_id    = cand_id;
        req_nmi   = nmi_pend && (state_q != ST_NMI);
        req_valid = req_nmi || ((state_q != ST_NMI) && preempt_ok);
        req_id    = cand_id;
        act_valid = (state_q != ST_IDLE);
        act_nmi   = (state_q == ST_NMI);
        act_id    = (state_q == ST_SERVE) ? top_id : '0;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_IRQ  = 32,
    parameter int PRIO_W = 2,
    localparam int ID_W  = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] irq_level,
    input  logic             nmi_in,
    input  logic             ack,
    input  logic             done,
    output logic             req_valid,
    output logic             req_nmi,
    output logic [ID_W-1:0]  req_id,
    output logic             act_valid,
    output logic             act_nmi,
    output logic [ID_W-1:0]  act_id
);
    logic [N_IRQ-1:0]        en_q, pend_q;
    logic [N_IRQ*PRIO_W-1:0] prio_flat;
    logic                    cand_ok, clr_valid;
    logic [ID_W-1:0]         cand_id, clr_id;
    logic [PRIO_W-1:0]       cand_prio;

    pic_regfile #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_level(irq_level), .clr_valid(clr_valid),
        .clr_id(clr_id), .en_q(en_q), .pend_q(pend_q), .prio_flat(prio_flat)
    );

    pic_select #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_sel (
        .en_q(en_q), .pend_q(pend_q), .prio_flat(prio_flat),
        .cand_ok(cand_ok), .cand_id(cand_id), .cand_prio(cand_prio)
    );

    pic_sequencer #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .ack(ack), .done(done),
        .cand_ok(cand_ok), .cand_id(cand_id), .cand_prio(cand_prio),
        .prio_flat(prio_flat), .clr_valid(clr_valid), .clr_id(clr_id),
        .req_valid(req_valid), .req_nmi(req_nmi), .req_id(req_id),
        .act_valid(act_valid), .act_nmi(act_nmi), .act_id(act_id)
    );
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int N_IRQ  = 32,
    localparam int ID_W  = $clog2(N_IRQ)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             done,
    input logic             req_valid,
    input logic             req_nmi,
    input logic [ID_W-1:0]  req_id,
    input logic             act_valid,
    input logic             act_nmi,
    input logic [ID_W-1:0]  act_id,
    input logic [N_IRQ-1:0] en_q,
    input logic [N_IRQ-1:0] pend_q
);
    // R5: a configurable request always names a live line
    p_req_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_nmi) |-> (en_q[req_id] && pend_q[req_id]));

    // R8: accepting a configurable request activates that line
    p_ack_activates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_valid && !req_nmi && !done)
            |=> (act_valid && !act_nmi && act_id == $past(req_id)));

    // R11: accepting the non-maskable request enters its handler
    p_nmi_enter_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_nmi && !done) |=> act_nmi);

    // R11: nothing is offered while the non-maskable handler runs
    p_nmi_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act_nmi |-> !req_valid);

    // R12: the non-maskable flag never stands without an active handler
    p_idle_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |-> !act_nmi);
endmodule

bind prio_irq_ctrl pic_checker #(.N_IRQ(N_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .done(done),
    .req_valid(req_valid), .req_nmi(req_nmi), .req_id(req_id),
    .act_valid(act_valid), .act_nmi(act_nmi), .act_id(act_id),
    .en_q(en_q), .pend_q(pend_q)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] irq_in = '0, irq_level = '0;
    logic        nmi_in = 1'b0, ack = 1'b0, done = 1'b0;
    logic        req_valid, req_nmi, act_valid, act_nmi;
    logic [4:0]  req_id, act_id;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;   // 125 MHz

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_level(irq_level), .nmi_in(nmi_in),
        .ack(ack), .done(done), .req_valid(req_valid), .req_nmi(req_nmi),
        .req_id(req_id), .act_valid(act_valid), .act_nmi(act_nmi), .act_id(act_id)
    );

    typedef struct packed {
        logic [7:0]  en;
        logic [7:0]  pend;
        logic [15:0] lv;   // level of line i at bits [2i+1:2i]
        logic        v;
        logic [4:0]  id;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'h01, 8'h01, 16'h0000, 1'b1, 5'd0},
        '{8'hFF, 8'h00, 16'h0000, 1'b0, 5'd0},
        '{8'h0F, 8'hF0, 16'h0000, 1'b0, 5'd0},
        '{8'hFF, 8'h0C, 16'h0070, 1'b1, 5'd3},
        '{8'hFF, 8'hA0, 16'hAAAA, 1'b1, 5'd5},
        '{8'h7F, 8'hC0, 16'h3000, 1'b1, 5'd6},
        '{8'hFF, 8'hFF, 16'hF5BF, 1'b1, 5'd4}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic wipe();
        wr(12'h180, 32'hFFFF_FFFF);
        wr(12'h280, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) wr(12'h400 + 12'(4 * k), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req", {30'b0, req_valid, act_valid}, 32'h0);
        chk("R1 nmi", {31'b0, act_nmi}, 32'h0);
        rd(12'h100, rv); chk("R1 enable", rv, 32'h0);
        rd(12'h280, rv); chk("R1 pending", rv, 32'h0);
        rd(12'h41C, rv); chk("R1 prio", rv, 32'h0);

        // R5 selection table
        foreach (VECS[i]) begin
            logic [31:0] w0, w1;
            w0 = '0; w1 = '0;
            for (int j = 0; j < 4; j++) begin
                w0[8*j+6 +: 2] = VECS[i].lv[2*j +: 2];
                w1[8*j+6 +: 2] = VECS[i].lv[2*(j+4) +: 2];
            end
            wipe();
            wr(12'h400, w0);
            wr(12'h404, w1);
            wr(12'h100, {24'b0, VECS[i].en});
            wr(12'h200, {24'b0, VECS[i].pend});
            chk("R5 select", {26'b0, req_valid, req_valid ? req_id : 5'd0},
                {26'b0, VECS[i].v, VECS[i].v ? VECS[i].id : 5'd0});
        end
        wipe();

        // R2 enable set/clear
        wr(12'h100, 32'h11);
        rd(12'h180, rv); chk("R2 set", rv, 32'h11);
        wr(12'h100, 32'h4);
        rd(12'h100, rv); chk("R2 zero bits ignored", rv, 32'h15);
        wr(12'h180, 32'h1);
        rd(12'h100, rv); chk("R2 clear", rv, 32'h14);

        // R3 pending set/clear
        wr(12'h200, 32'h3);
        wr(12'h280, 32'h1);
        rd(12'h200, rv); chk("R3 pending", rv, 32'h2);

        // R4 priority field layout
        wr(12'h404, 32'hFFFF_FFFF);
        rd(12'h404, rv); chk("R4 layout", rv, 32'hC0C0_C0C0);
        wipe();

        // R6 pulse line 9
        wr(12'h100, 32'h200);
        @(negedge clk); irq_in[9] = 1'b1;
        @(negedge clk); irq_in[9] = 1'b0;
        rd(12'h200, rv); chk("R6 latched", rv, 32'h200);
        chk("R6 request", {26'b0, req_valid, req_id}, {26'b0, 1'b1, 5'd9});

        // R8 acknowledge
        pulse_ack();
        chk("R8 active", {26'b0, act_valid, act_id}, {26'b0, 1'b1, 5'd9});
        rd(12'h200, rv); chk("R8 pending cleared", rv, 32'h0);

        // R12 retire
        pulse_done();
        chk("R12 idle", {31'b0, act_valid}, 32'h0);

        // R6 held-high pulse line does not re-set after clear
        @(negedge clk); irq_in[9] = 1'b1;
        @(negedge clk);
        wr(12'h280, 32'h200);
        @(negedge clk);
        rd(12'h200, rv); chk("R6 no re-set", rv, 32'h0);
        irq_in[9] = 1'b0;
        wipe();

        // R9 / R10 nesting and chaining: lines 10,11 level 2, line 12 level 0
        wr(12'h408, 32'h8080_0000);
        wr(12'h100, 32'h1C00);
        wr(12'h200, 32'h0400);
        pulse_ack();
        chk("R9 first active", {26'b0, act_valid, act_id}, {26'b0, 1'b1, 5'd10});
        wr(12'h200, 32'h0800);
        chk("R9 equal level no preempt", {31'b0, req_valid}, 32'h0);
        wr(12'h200, 32'h1000);
        chk("R9 urgent request", {26'b0, req_valid, req_id}, {26'b0, 1'b1, 5'd12});
        pulse_ack();
        chk("R9 nested active", {27'b0, act_id}, 32'd12);
        pulse_done();
        chk("R9 return", {26'b0, act_valid, act_id}, {26'b0, 1'b1, 5'd10});
        pulse_done();
        chk("R10 chain", {26'b0, act_valid, act_id}, {26'b0, 1'b1, 5'd11});
        pulse_done();
        chk("R12 idle after chain", {31'b0, act_valid}, 32'h0);
        wipe();

        // R7 level line 13
        irq_level[13] = 1'b1;
        wr(12'h100, 32'h2000);
        @(negedge clk); irq_in[13] = 1'b1;
        @(negedge clk);
        chk("R7 request", {26'b0, req_valid, req_id}, {26'b0, 1'b1, 5'd13});
        pulse_ack();
        rd(12'h200, rv); chk("R7 reasserted", rv, 32'h2000);
        irq_in[13] = 1'b0;
        wr(12'h280, 32'h2000);
        rd(12'h200, rv); chk("R7 cleared after drop", rv, 32'h0);
        pulse_done();
        irq_level[13] = 1'b0;
        wipe();

        // R11 non-maskable
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk);
        chk("R11 nmi request disabled lines", {30'b0, req_valid, req_nmi}, 32'h3);
        wr(12'h100, 32'h4000);
        wr(12'h200, 32'h4000);
        chk("R11 nmi wins", {31'b0, req_nmi}, 32'h1);
        pulse_ack();
        chk("R11 nmi active", {30'b0, act_nmi, req_valid}, 32'h2);
        nmi_in = 1'b0;
        pulse_done();
        chk("R11 exit", {24'b0, act_valid, act_nmi, req_valid, req_id},
            {24'b0, 1'b0, 1'b0, 1'b1, 5'd14});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule